// File: doc/BRIEF.md
# Multi-Drop Serial Receiver with Address Wake-Up

This block receives asynchronous serial characters from a line shared by several listeners. Each character carries one extra bit after its eight data bits. A 1 in that bit marks the character as a station address; a 0 marks it as payload. The block has no parity bit. Bit timing comes from an external sample tick that runs at sixteen times the bit rate. Each bit is read once, at the middle of its bit period.

Software can arm a wake-up filter. While the filter is armed, the receiver discards payload characters without a trace: the receive register does not change, and no flag or interrupt is raised. The first address character ends the filter. Hardware disarms the filter, and the address character is handled like any normal character. Software then compares the address with its own station number; this block does not do that comparison. If the address does not match, software re-arms the filter.

The filter state is captured when a start bit is detected. A software write during a character therefore applies from the next character onward.

Top module: `mpuart_rx`

## Requirements
- R1: A character has this format: a start bit (low), eight data bits sent LSB first, the address-marker bit, then a stop bit (high). There is no parity. The data bits appear on `rdata_o` with bit 0 = first data bit received. The marker bit appears on `mpb_o`.
- R2: A low level seen on a tick while idle only starts a character if the line is still low on the 8th tick (the half-bit point). If the line is high there, the receiver returns to idle and delivers nothing. Each later bit is sampled 16 ticks after the previous sample.
- R3: All outputs are 0 after reset. A completed character is loaded into `rdata_o`/`mpb_o` and sets `rfull_o` when the filter is inactive for it and the register is empty. A `rd_ack_i` pulse clears `rfull_o`. If a load and `rd_ack_i` happen on the same edge, the register ends up full.
- R4: A character with marker bit 0, received while its captured filter value is 1, changes nothing. `rdata_o`, `rfull_o`, `mpb_o`, `ovr_o`, `fer_o` and `rxi_o` all stay as they were, even if its stop bit is low or the register is full.
- R5: `fer_o` is set when a delivered character has a low stop bit. That character is still loaded if the register is empty.
- R6: When a delivered character completes while `rfull_o` is 1 and no `rd_ack_i` arrives on that edge, `ovr_o` is set. `rdata_o`, `mpb_o` and `rfull_o` keep the old character, and no interrupt is raised.
- R7: A character with marker bit 1, received while its captured filter value is 1, clears `wake_en_o` on its completion edge. It is then delivered as in R3, R5 and R6, with `mpb_o` = 1.
- R8: `wake_en_o` follows each `wake_wr_i` write (`wake_wdata_i`) on the next edge. A write beats a hardware clear on the same edge. The filter value used for a character is the value of `wake_en_o` when its start bit is detected.
- R9: `rxi_o` pulses high for one cycle on the edge that loads a character, if `rie_i` is 1 at that edge. It does not pulse otherwise.
- R10: `err_clr_i` clears `ovr_o` and `fer_o`. If an error is set on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high, asynchronous |
| tick_i | input | 1 | Sample tick, 16 per bit period, one clock wide |
| wake_wr_i | input | 1 | Write strobe for the wake-up filter enable |
| wake_wdata_i | input | 1 | Value written to the filter enable |
| rie_i | input | 1 | Receive interrupt enable |
| rd_ack_i | input | 1 | Software has read the receive register |
| err_clr_i | input | 1 | Clear overrun and framing flags |
| rdata_o | output | 8 | Receive data register |
| rfull_o | output | 1 | Receive register holds an unread character |
| mpb_o | output | 1 | Marker bit of the character in the receive register |
| ovr_o | output | 1 | Overrun flag |
| fer_o | output | 1 | Framing-error flag |
| wake_en_o | output | 1 | Current wake-up filter enable |
| rxi_o | output | 1 | Receive interrupt pulse |

## Verification
Characters are sent with marker bits 0 and 1. This tells payload handling apart from address handling, with the filter both armed and disarmed. A low stop bit, a full register and a too-short start pulse separate framing, overrun and false-start behaviour from the plain delivery path. Filter writes placed in the middle of a character, and on the completion edge itself, show whether the start-bit capture and the write-over-clear priority hold. A clear pulse that overlaps an error shows that the set wins.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_SHIFT = 2'd2
  } mpr_state_e;

endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/mpr_bitsync.sv
module mpr_bitsync
  import mpr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              wake_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              mpb_o,
  output logic              stop_o,
  output logic              filt_o
);

  localparam int CNT_W    = $clog2(OVS);
  localparam int HALF     = OVS / 2;
  localparam int NBITS    = DATA_W + 2;
  localparam int IDX_W    = $clog2(NBITS + 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NBITS - 1);

  mpr_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W:0]   sh_q, sh_d;
  logic              filt_q, filt_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    filt_d = filt_q;
    done_o = 1'b0;
    if (tick_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (!rx_i) begin
            st_d   = ST_START;
            cnt_d  = CNT_W'(1);
            filt_d = wake_i;
          end
        end
        ST_START: begin
          if (cnt_q == CNT_HALF) begin
            cnt_d = '0;
            idx_d = '0;
            st_d  = rx_i ? ST_IDLE : ST_SHIFT;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (cnt_q == CNT_LAST) begin
            cnt_d = '0;
            if (idx_q == IDX_LAST) begin
              st_d   = ST_IDLE;
              done_o = 1'b1;
            end else begin
              sh_d  = {rx_i, sh_q[DATA_W:1]};
              idx_d = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      filt_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      filt_q <= filt_d;
    end
  end

  assign data_o = sh_q[DATA_W-1:0];
  assign mpb_o  = sh_q[DATA_W];
  assign stop_o = rx_i;
  assign filt_o = filt_q;

endmodule

// File: rtl/mpr_rxreg.sv
module mpr_rxreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              mpb_i,
  input  logic              stop_i,
  input  logic              filt_i,
  input  logic              wake_wr_i,
  input  logic              wake_wdata_i,
  input  logic              rie_i,
  input  logic              rd_ack_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rfull_o,
  output logic              mpb_o,
  output logic              ovr_o,
  output logic              fer_o,
  output logic              wake_o,
  output logic              rxi_o
);

  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              full_q, full_d;
  logic              mpb_q, mpb_d;
  logic              ovr_q, ovr_d;
  logic              fer_q, fer_d;
  logic              wake_q, wake_d;
  logic              rxi_q, rxi_d;
  logic              accept, busy, load;

  always_comb begin
    accept  = done_i & (~filt_i | mpb_i);
    busy    = full_q & ~rd_ack_i;
    load    = accept & ~busy;
    rdata_d = load ? data_i : rdata_q;
    mpb_d   = load ? mpb_i  : mpb_q;
    full_d  = load | busy;
    ovr_d   = (accept & busy)    | (ovr_q & ~err_clr_i);
    fer_d   = (accept & ~stop_i) | (fer_q & ~err_clr_i);
    rxi_d   = load & rie_i;
    if (wake_wr_i)                    wake_d = wake_wdata_i;
    else if (done_i & filt_i & mpb_i) wake_d = 1'b0;
    else                              wake_d = wake_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      full_q  <= 1'b0;
      mpb_q   <= 1'b0;
      ovr_q   <= 1'b0;
      fer_q   <= 1'b0;
      wake_q  <= 1'b0;
      rxi_q   <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      full_q  <= full_d;
      mpb_q   <= mpb_d;
      ovr_q   <= ovr_d;
      fer_q   <= fer_d;
      wake_q  <= wake_d;
      rxi_q   <= rxi_d;
    end
  end

  assign rdata_o = rdata_q;
  assign rfull_o = full_q;
  assign mpb_o   = mpb_q;
  assign ovr_o   = ovr_q;
  assign fer_o   = fer_q;
  assign wake_o  = wake_q;
  assign rxi_o   = rxi_q;

endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick_i,
  input  logic              wake_wr_i,
  input  logic              wake_wdata_i,
  input  logic              rie_i,
  input  logic              rd_ack_i,
  input  logic              err_clr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rfull_o,
  output logic              mpb_o,
  output logic              ovr_o,
  output logic              fer_o,
  output logic              wake_en_o,
  output logic              rxi_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              rx_s;
  logic              frm_done;
  logic [DATA_W-1:0] frm_data;
  logic              frm_mpb;
  logic              frm_stop;
  logic              frm_filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  mpr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  mpr_bitsync #(.DATA_W(DATA_W), .OVS(OVS)) u_bits (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .tick_i (tick_i),
    .rx_i   (rx_s),
    .wake_i (wake_en_o),
    .done_o (frm_done),
    .data_o (frm_data),
    .mpb_o  (frm_mpb),
    .stop_o (frm_stop),
    .filt_o (frm_filt)
  );

  mpr_rxreg #(.DATA_W(DATA_W)) u_reg (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .done_i       (frm_done),
    .data_i       (frm_data),
    .mpb_i        (frm_mpb),
    .stop_i       (frm_stop),
    .filt_i       (frm_filt),
    .wake_wr_i    (wake_wr_i),
    .wake_wdata_i (wake_wdata_i),
    .rie_i        (rie_i),
    .rd_ack_i     (rd_ack_i),
    .err_clr_i    (err_clr_i),
    .rdata_o      (rdata_o),
    .rfull_o      (rfull_o),
    .mpb_o        (mpb_o),
    .ovr_o        (ovr_o),
    .fer_o        (fer_o),
    .wake_o       (wake_en_o),
    .rxi_o        (rxi_o)
  );

endmodule

// File: rtl/mpr_rx_chk.sv
module mpr_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              filt,
  input logic              mpb,
  input logic              stop_ok,
  input logic              wake_wr,
  input logic              wake_wdata,
  input logic              rie,
  input logic [DATA_W-1:0] rdata,
  input logic              rfull,
  input logic              mpb_o,
  input logic              ovr,
  input logic              fer,
  input logic              wake_en,
  input logic              rxi
);

  AST_FILTER_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    done && filt && !mpb |=> $stable(rdata) && !rxi && !$rose(ovr) && !$rose(fer)); // R4

  AST_FER_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fer) |-> $past(done && !stop_ok)); // R5

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $stable(rdata) && $stable(mpb_o)); // R6

  AST_WAKE_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wake_en) && !$past(wake_wr) |-> $past(done && filt && mpb)); // R7

  AST_WAKE_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wake_wr) |-> wake_en == $past(wake_wdata)); // R8

  AST_RXI_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rxi |-> rfull && $past(rie)); // R9

endmodule

bind mpuart_rx mpr_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .done       (frm_done),
  .filt       (frm_filt),
  .mpb        (frm_mpb),
  .stop_ok    (frm_stop),
  .wake_wr    (wake_wr_i),
  .wake_wdata (wake_wdata_i),
  .rie        (rie_i),
  .rdata      (rdata_o),
  .rfull      (rfull_o),
  .mpb_o      (mpb_o),
  .ovr        (ovr_o),
  .fer        (fer_o),
  .wake_en    (wake_en_o),
  .rxi        (rxi_o)
);

// File: tb/mpuart_rx_tb_top.sv
`timescale 1ns/1ps
module mpuart_rx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       wake_wr_i = 1'b0;
  logic       wake_wdata_i = 1'b0;
  logic       rie_i = 1'b1;
  logic       rd_ack_i = 1'b0;
  logic       err_clr_i = 1'b0;
  logic [7:0] rdata_o;
  logic       rfull_o, mpb_o, ovr_o, fer_o, wake_en_o, rxi_o;

  int checks = 0;
  int fails  = 0;
  int rxi_seen = 0;
  int tdiv = 0;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;

  // reference model state
  logic [7:0] m_rdata = '0;
  bit m_full = 0, m_mpb = 0, m_ovr = 0, m_fer = 0, m_wake = 0, m_rxi = 0, m_filt = 0;
  bit ev_latch = 0, ev_done = 0;
  logic [7:0] e_data;
  bit e_mpb, e_stop;

  always #2 clk = ~clk;

  mpuart_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i), .tick_i(tick_i),
    .wake_wr_i(wake_wr_i), .wake_wdata_i(wake_wdata_i), .rie_i(rie_i),
    .rd_ack_i(rd_ack_i), .err_clr_i(err_clr_i), .rdata_o(rdata_o),
    .rfull_o(rfull_o), .mpb_o(mpb_o), .ovr_o(ovr_o), .fer_o(fer_o),
    .wake_en_o(wake_en_o), .rxi_o(rxi_o)
  );

  always @(negedge clk) begin
    tdiv   = (tdiv == 3) ? 0 : tdiv + 1;
    tick_i = (tdiv == 0);
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: updated on every edge from the bench's own view of the frames
  always @(posedge clk) begin
    bit n_full, n_ovr, n_fer, n_wake, busy;
    if (!rst_n) begin
      m_rdata = '0; m_full = 0; m_mpb = 0; m_ovr = 0; m_fer = 0;
      m_wake = 0; m_rxi = 0; m_filt = 0;
    end else begin
      busy   = m_full && !rd_ack_i;
      n_full = busy;
      n_ovr  = m_ovr && !err_clr_i;
      n_fer  = m_fer && !err_clr_i;
      n_wake = m_wake;
      m_rxi  = 0;
      if (ev_latch && tick_i) begin
        m_filt   = m_wake;
        ev_latch = 0;
      end
      if (ev_done && tick_i) begin
        ev_done = 0;
        if (!m_filt || e_mpb) begin
          if (busy) n_ovr = 1;
          else begin
            m_rdata = e_data; m_mpb = e_mpb; n_full = 1; m_rxi = rie_i;
          end
          if (!e_stop) n_fer = 1;
          if (m_filt) n_wake = 0;
        end
      end
      if (wake_wr_i) n_wake = wake_wdata_i;
      m_full = n_full; m_ovr = n_ovr; m_fer = n_fer; m_wake = n_wake;
    end
  end

  always @(negedge clk) begin
    if (rxi_o === 1'b1) rxi_seen++;
    if (cmp_en) begin
      chk("R3", "rdata", rdata_o, m_rdata);
      chk("R3", "rfull", rfull_o, m_full);
      chk("R1", "mpb", mpb_o, m_mpb);
      chk("R6", "ovr", ovr_o, m_ovr);
      chk("R5", "fer", fer_o, m_fer);
      chk("R8", "wake", wake_en_o, m_wake);
      chk("R9", "rxi", rxi_o, m_rxi);
    end
  end

  task automatic wait_tick();
    do @(posedge clk); while (tick_i !== 1'b1);
  endtask

  task automatic send(input logic [7:0] d, input bit mpb, input bit stop,
                      input bit hook_wr, input bit hook_clr);
    logic [10:0] bits;
    bits = {stop, mpb, d, 1'b0};
    wait_tick();
    for (int j = 0; j < 11; j++) begin
      @(negedge clk);
      rx_i = bits[j];
      if (j == 0) ev_latch = 1;
      if (j < 10) repeat (16) wait_tick();
      else begin
        repeat (7) wait_tick();
        @(negedge clk);
        e_data = d; e_mpb = mpb; e_stop = stop; ev_done = 1;
        if (hook_wr) begin wake_wr_i = 1; wake_wdata_i = 1; end
        if (hook_clr) err_clr_i = 1;
        wait_tick();
        @(negedge clk);
        wake_wr_i = 0; err_clr_i = 0; rx_i = 1;
        repeat (8) wait_tick();
      end
    end
  endtask

  task automatic glitch();
    wait_tick();
    @(negedge clk) rx_i = 0;
    repeat (3) wait_tick();
    @(negedge clk) rx_i = 1;
    repeat (20) wait_tick();
  endtask

  task automatic wr_wake(input bit v);
    @(negedge clk); wake_wr_i = 1; wake_wdata_i = v;
    @(negedge clk); wake_wr_i = 0;
  endtask

  task automatic ack();
    @(negedge clk); rd_ack_i = 1;
    @(negedge clk); rd_ack_i = 0;
  endtask

  task automatic clr();
    @(negedge clk); err_clr_i = 1;
    @(negedge clk); err_clr_i = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int r0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R3", "reset rfull", rfull_o, 0);
    chk("R3", "reset flags", {ovr_o, fer_o, wake_en_o, rxi_o, mpb_o}, 0);
    chk("R3", "reset rdata", rdata_o, 0);
    cmp_en = 1;

    r0 = rxi_seen;
    send(8'hA5, 0, 1, 0, 0);
    chk("R1", "lsb-first data", rdata_o, 8'hA5);
    chk("R3", "full after load", rfull_o, 1);
    chk("R9", "one rxi pulse", rxi_seen - r0, 1);

    ack();
    chk("R3", "ack clears full", rfull_o, 0);
    send(8'h3C, 1, 1, 0, 0);
    chk("R1", "marker bit status", mpb_o, 1);

    send(8'h55, 0, 1, 0, 0);
    chk("R6", "overrun set", ovr_o, 1);
    chk("R6", "old data kept", rdata_o, 8'h3C);

    clr(); ack();
    chk("R10", "clear flags", ovr_o, 0);
    send(8'h81, 0, 0, 0, 0);
    chk("R5", "framing set", fer_o, 1);
    chk("R5", "data loaded", rdata_o, 8'h81);

    clr(); ack();
    glitch();
    chk("R2", "false start ignored", rfull_o, 0);
    send(8'h12, 0, 1, 0, 0);
    chk("R2", "next frame ok", rdata_o, 8'h12);

    ack(); wr_wake(1);
    r0 = rxi_seen;
    send(8'h77, 0, 1, 0, 0);
    chk("R4", "discard no load", rfull_o, 0);
    send(8'h66, 0, 0, 0, 0);
    chk("R4", "discard no fer", fer_o, 0);
    chk("R4", "discard no rxi", rxi_seen - r0, 0);
    chk("R4", "filter stays", wake_en_o, 1);

    wr_wake(0);
    send(8'h01, 0, 1, 0, 0);
    wr_wake(1);
    send(8'h02, 0, 1, 0, 0);
    chk("R4", "discard no ovr", ovr_o, 0);
    chk("R4", "discard keeps data", rdata_o, 8'h01);
    send(8'h05, 1, 1, 0, 0);
    chk("R7", "id clears filter", wake_en_o, 0);
    chk("R7", "id overrun normal", ovr_o, 1);

    clr(); ack(); wr_wake(1);
    send(8'h09, 1, 1, 0, 0);
    chk("R7", "id delivered", rdata_o, 8'h09);
    chk("R7", "id marker", mpb_o, 1);
    chk("R7", "filter off", wake_en_o, 0);

    ack();
    fork
      send(8'h44, 0, 1, 0, 0);
      begin repeat (60) wait_tick(); wr_wake(1); end
    join
    chk("R8", "latched off delivers", rdata_o, 8'h44);
    chk("R8", "write took effect", wake_en_o, 1);
    send(8'h45, 0, 1, 0, 0);
    chk("R8", "next frame filtered", rdata_o, 8'h44);

    ack();
    fork
      send(8'h46, 0, 1, 0, 0);
      begin repeat (60) wait_tick(); wr_wake(0); end
    join
    chk("R8", "latched on discards", rfull_o, 0);

    wr_wake(1);
    send(8'h20, 1, 1, 1, 0);
    chk("R8", "write beats hw clear", wake_en_o, 1);
    chk("R7", "id data", rdata_o, 8'h20);

    ack(); wr_wake(0);
    @(negedge clk) rie_i = 0;
    r0 = rxi_seen;
    send(8'h33, 0, 0, 0, 1);
    chk("R9", "no rxi when disabled", rxi_seen - r0, 0);
    chk("R10", "set beats clear", fer_o, 1);
    chk("R5", "data with bad stop", rdata_o, 8'h33);

    repeat (10) @(negedge clk);
    finish_run();
  end

endmodule